// File: doc/BRIEF.md
# Two-Wire Register-File Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data, both open drain). It answers one fixed 7-bit device address and exposes a 64-byte space through a single 6-bit pointer that advances by itself. Bytes 0 to 7 belong to a neighbouring clock core and are reached through a small byte port. Bytes 8 to 63 are general-purpose storage held inside the block.

A master first writes a word address to load the pointer. It then either streams data bytes in, or issues a repeated START and reads bytes out. A read that is not preceded by a pointer write starts at whatever the pointer last held. While the pointer sits on a live time byte during a read, a busy flag tells the clock core to hold off its update. A power-fail input aborts any transfer, clears the pointer and deafens the slave to the bus for as long as it stays high.

Top module: `twi_regfile_slave`

## Requirements
- R1: The slave acknowledges only the device byte 0xD0 (write) or 0xD1 (read), i.e. 7-bit address 0x68 with the direction in bit 0 (1 = read). Any other device byte gets no acknowledge, and the rest of that transfer is ignored.
- R2: START (SDA falls while SCL is high) always restarts the device-address phase, even without a preceding STOP. STOP (SDA rises while SCL is high) returns the slave to idle, and clocked bytes that are not preceded by a START get no acknowledge.
- R3: In a write transfer the first byte after the device byte loads the pointer from its low 6 bits. Each later byte is stored at the pointer, and the pointer then advances by one when the acknowledge clock ends. The slave acknowledges every one of these bytes.
- R4: In a read transfer the slave shifts out the byte at the pointer, MSB first. The pointer advances by one only when the master acknowledges that byte.
- R5: A master NACK ends the read: SDA stays released and the pointer stays on the last byte sent.
- R6: A read that is not preceded by a pointer write begins at the retained pointer value.
- R7: The pointer wraps from 63 to 0, for writes and for reads.
- R8: A write to bytes 0 to 7 raises core_we for exactly one system clock, with core_addr equal to the pointer and core_wdata equal to the byte. Writes to bytes 8 to 63 never raise core_we. Reads of bytes 0 to 7 return core_rdata.
- R9: core_rd_busy is high while a read transfer is in progress and the pointer is between 0 and 6, and it is low otherwise.
- R10: While pwr_fail is high, SDA is released, the pointer is held at 0 and all bus activity is ignored. This includes a START and a correct device byte.
- R11: The slave changes SDA only while SCL is low.
- R12: After reset SDA is released, core_we and core_rd_busy are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail | input | 1 | Supply out of tolerance, synchronous to clk |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| core_addr | output | 3 | Byte index into the clock-core bytes |
| core_wdata | output | 8 | Byte written to the clock core |
| core_we | output | 1 | One-cycle write strobe to the clock core |
| core_rdata | input | 8 | Clock-core byte at core_addr, combinational |
| core_rd_busy | output | 1 | A read of a live time byte is in progress |

## Verification
The assertions assume that the bus lines change only while SCL is low, except at START and STOP. They also assume that each SCL phase lasts well beyond the two-flop synchroniser latency, and that pwr_fail is synchronous to clk. The behavioural master keeps to these rules: it holds each quarter bit for six system clocks and moves SDA only after SCL has been low for a full quarter. It raises pwr_fail only while SCL is low. The slave's own SDA changes follow synchronised SCL falls, so they never meet a high SCL at the pads.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_RDAT
  } twi_state_t;

  // next pointer value inside a space of 'space' bytes
  function automatic int unsigned ptr_after(int unsigned p, int unsigned space);
    return (p + 1 >= space) ? 0 : p + 1;
  endfunction

  // device byte carries our 7-bit address in its upper bits
  function automatic logic addr_hit(logic [7:0] rx, logic [6:0] dev);
    return rx[7:1] == dev;
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= synced;
  end

  assign scl_s    = synced[0];
  assign sda_s    = synced[1];
  assign ev_start = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign ev_stop  = synced[0] & prev[0] & ~prev[1] & synced[1];
  assign ev_rise  = synced[0] & ~prev[0];
  assign ev_fall  = ~synced[0] & prev[0];
endmodule

// File: rtl/twi_gp_ram.sv
module twi_gp_ram #(
  parameter int AW    = 6,
  parameter int DW    = 8,
  parameter int BASE  = 8,
  parameter int DEPTH = 56
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] idx;
  logic          in_range;

  assign idx      = addr - BASE_A;
  assign in_range = (addr >= BASE_A) && (32'(idx) < DEPTH);

  always_ff @(posedge clk) begin
    if (we && in_range) mem[idx] <= wdata;
  end

  assign rdata = in_range ? mem[idx] : '0;
endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave #(
  parameter logic [6:0] DEV_ADDR   = 7'h68,
  parameter int         SPACE      = 64,
  parameter int         CORE_BYTES = 8,
  parameter int         BUSY_BELOW = 7,
  parameter int         SYNC       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_fail,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic [2:0] core_addr,
  output logic [7:0] core_wdata,
  output logic       core_we,
  input  logic [7:0] core_rdata,
  output logic       core_rd_busy
);
  import twi_pkg::*;

  localparam int AW  = $clog2(SPACE);
  localparam int CAW = $clog2(CORE_BYTES);
  localparam int RAM_DEPTH = SPACE - CORE_BYTES;
  localparam logic [AW-1:0] CORE_LIM = AW'(CORE_BYTES);
  localparam logic [AW-1:0] BUSY_LIM = AW'(BUSY_BELOW);
  localparam logic [3:0] BIT_LAST = 4'd8;
  localparam logic [3:0] ACK_SLOT = 4'd9;

  // bus events (named for the checker)
  logic scl_s, sda_s, ev_start, ev_stop, ev_rise, ev_fall;

  twi_line_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  twi_state_t    state;
  logic [3:0]    cnt;
  logic [7:0]    shreg;
  logic [AW-1:0] ptr;
  logic          is_read;
  logic          mack;

  logic byte_done, ack_end, wr_strobe, in_core;
  logic [7:0] ram_rdata, cur_rdata;

  assign byte_done = ev_fall && (cnt == BIT_LAST);
  assign ack_end   = ev_fall && (cnt == ACK_SLOT);
  assign wr_strobe = byte_done && (state == ST_WDAT) && !pwr_fail;
  assign in_core   = ptr < CORE_LIM;

  twi_gp_ram #(.AW(AW), .DW(8), .BASE(CORE_BYTES), .DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .we(wr_strobe && !in_core), .addr(ptr),
    .wdata(shreg), .rdata(ram_rdata)
  );

  assign cur_rdata    = in_core ? core_rdata : ram_rdata;
  assign core_addr    = ptr[CAW-1:0];
  assign core_wdata   = shreg;
  assign core_we      = wr_strobe && in_core;
  assign core_rd_busy = (state == ST_RDAT) && (ptr < BUSY_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      ptr      <= '0;
      is_read  <= 1'b0;
      mack     <= 1'b1;
      sda_pull <= 1'b0;
    end else if (pwr_fail) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ptr      <= '0;
      sda_pull <= 1'b0;
    end else if (ev_start) begin
      state    <= ST_DEV;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (ev_stop) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (ev_rise) begin
        if (cnt < BIT_LAST) begin
          if (state != ST_RDAT) shreg <= {shreg[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (cnt == ACK_SLOT && state == ST_RDAT) begin
          mack <= sda_s;
          if (!sda_s) ptr <= AW'(ptr_after(32'(ptr), SPACE));
        end
      end else if (ev_fall) begin
        if (cnt == BIT_LAST) begin
          cnt <= ACK_SLOT;
          case (state)
            ST_DEV: begin
              if (addr_hit(shreg, DEV_ADDR)) begin
                sda_pull <= 1'b1;
                is_read  <= shreg[0];
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_WADR: begin
              sda_pull <= 1'b1;
              ptr      <= shreg[AW-1:0];
            end
            ST_WDAT: sda_pull <= 1'b1;
            default: sda_pull <= 1'b0;
          endcase
        end else if (cnt == ACK_SLOT) begin
          cnt      <= '0;
          sda_pull <= 1'b0;
          case (state)
            ST_DEV: begin
              if (is_read) begin
                state    <= ST_RDAT;
                shreg    <= cur_rdata;
                sda_pull <= !cur_rdata[7];
              end else begin
                state <= ST_WADR;
              end
            end
            ST_WADR: state <= ST_WDAT;
            ST_WDAT: ptr <= AW'(ptr_after(32'(ptr), SPACE));
            ST_RDAT: begin
              if (!mack) begin
                shreg    <= cur_rdata;
                sda_pull <= !cur_rdata[7];
              end else begin
                state <= ST_IDLE;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end else if (state == ST_RDAT && cnt != 4'd0) begin
          shreg    <= {shreg[6:0], 1'b0};
          sda_pull <= !shreg[6];
        end
      end
    end
  end
endmodule

// File: rtl/twi_regfile_slave_chk.sv
module twi_regfile_slave_chk #(
  parameter int AW    = 6,
  parameter int SPACE = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwr_fail,
  input logic                scl_s,
  input logic                ev_stop,
  input logic                ack_end,
  input twi_pkg::twi_state_t state,
  input logic                mack,
  input logic [AW-1:0]       ptr,
  input logic                sda_pull,
  input logic                core_we
);
  import twi_pkg::*;

  // R10
  pf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (!sda_pull && ptr == '0));

  // R11
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !pwr_fail && !$past(pwr_fail)) |-> $stable(sda_pull));

  // R8
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_we |=> !core_we);

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !pwr_fail) |=> (state == ST_IDLE && !sda_pull));

  // R3
  wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WDAT && ack_end && !pwr_fail)
      |=> ptr == AW'(ptr_after(32'($past(ptr)), SPACE)));

  // R5
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDAT && ack_end && mack && !pwr_fail) |=> (state == ST_IDLE && !sda_pull));
endmodule

bind twi_regfile_slave twi_regfile_slave_chk #(.AW(AW), .SPACE(SPACE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .scl_s(scl_s),
  .ev_stop(ev_stop), .ack_end(ack_end), .state(state), .mack(mack),
  .ptr(ptr), .sda_pull(sda_pull), .core_we(core_we)
);

// File: tb/twi_regfile_slave_test.sv
module twi_regfile_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic done = 1'b0;

  logic       sda_pull, core_we, core_rd_busy;
  logic [2:0] core_addr;
  logic [7:0] core_wdata, core_rdata;
  logic [7:0] core_mem [8];
  logic [7:0] shadow [64];
  logic       sda_line;

  int checks = 0, errors = 0;
  int we_seen = 0, we_expect = 0, hold_viol = 0;
  int exp_ptr = 0;

  localparam int Q = 6;
  // each entry: {word address, data byte}
  localparam logic [13:0] VEC [8] = '{
    {6'd0, 8'h15}, {6'd3, 8'h02}, {6'd7, 8'h83}, {6'd8, 8'hA5},
    {6'd20, 8'h5A}, {6'd37, 8'hC3}, {6'd55, 8'h0F}, {6'd62, 8'hF0}
  };

  always #4 clk = ~clk;

  assign sda_line   = !(m_sda_low || sda_pull);
  assign core_rdata = core_mem[core_addr];

  twi_regfile_slave uut (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .scl_in(m_scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .core_addr(core_addr), .core_wdata(core_wdata), .core_we(core_we),
    .core_rdata(core_rdata), .core_rd_busy(core_rd_busy)
  );

  always @(posedge clk) begin
    if (core_we) begin
      core_mem[core_addr] <= core_wdata;
      we_seen <= we_seen + 1;
    end
  end

  // R11 monitor: slave output must not move while SCL stays high
  logic prev_scl = 1'b1, prev_pull = 1'b0;
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && sda_pull != prev_pull) hold_viol++;
    prev_scl  <= m_scl;
    prev_pull <= sda_pull;
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; q();
    m_scl = 1'b1; q();
    m_sda_low = 1'b1; q();
    m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; q();
    m_scl = 1'b1; q();
    m_sda_low = 1'b0; q();
  endtask

  task automatic send_bit(input logic b);
    m_sda_low = !b; q();
    m_scl = 1'b1; q(); q();
    m_scl = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda_low = 1'b0; q();
    m_scl = 1'b1; q();
    acked = !sda_line; q();
    m_scl = 1'b0; q();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b, output logic busy);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      q(); m_scl = 1'b1; q();
      b[i] = sda_line;
      if (i == 7) busy = core_rd_busy;
      q(); m_scl = 1'b0;
    end
    q(); m_sda_low = give_ack; q();
    m_scl = 1'b1; q(); q();
    m_scl = 1'b0; q();
    m_sda_low = 1'b0;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] first, input int n, input string req);
    logic ack;
    bus_start();
    send_byte(8'hD0, ack); check_eq("R1", ack, 1);
    send_byte({2'b00, a}, ack); check_eq(req, ack, 1);
    for (int i = 0; i < n; i++) begin
      int at;
      at = (a + i) % 64;
      send_byte(first + 8'(i), ack); check_eq(req, ack, 1);
      shadow[at] = first + 8'(i);
      if (at < 8) we_expect++;
    end
    bus_stop();
    exp_ptr = (a + n) % 64;
  endtask

  task automatic do_read(input logic set_ptr, input logic [5:0] a, input int n, input string req);
    logic ack, busy;
    logic [7:0] b;
    bus_start();
    if (set_ptr) begin
      send_byte(8'hD0, ack); check_eq("R1", ack, 1);
      send_byte({2'b00, a}, ack); check_eq("R3", ack, 1);
      exp_ptr = a;
      bus_start(); // repeated START, R2
    end
    send_byte(8'hD1, ack); check_eq("R1", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b, busy);
      check_eq(req, b, shadow[exp_ptr]);
      check_eq("R9", busy, (exp_ptr < 7) ? 1 : 0);
      if (i != n - 1) exp_ptr = (exp_ptr + 1) % 64;
    end
    check_eq("R5", sda_pull, 0);
    bus_stop();
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < 8; i++) begin
      core_mem[i] = 8'h40 + 8'(i);
      shadow[i]   = 8'h40 + 8'(i);
    end
    repeat (5) @(negedge clk);
    // R12 reset state
    check_eq("R12", sda_pull, 0);
    check_eq("R12", core_we, 0);
    check_eq("R12", core_rd_busy, 0);
    rst_n = 1'b1;
    q();
    // R12 / R6: pointer starts at 0, read without pointer write
    do_read(1'b0, 6'd0, 1, "R12");

    // table walk: single write then addressed read back
    for (int v = 0; v < 8; v++) begin
      logic [5:0] a;
      logic [7:0] d;
      a = VEC[v][13:8];
      d = VEC[v][7:0];
      do_write(a, d, 1, "R3");
      if (a < 8) check_eq("R8", core_mem[a[2:0]], d);
      do_read(1'b1, a, 1, "R4");
    end

    // burst write and burst read ending in NACK
    do_write(6'd10, 8'h31, 4, "R3");
    do_read(1'b1, 6'd10, 4, "R4");
    // current-address read repeats last byte since NACK did not advance
    do_read(1'b0, 6'd0, 1, "R5");
    do_read(1'b0, 6'd0, 2, "R6");

    // burst crossing from core bytes into storage, busy flag
    do_write(6'd5, 8'h70, 4, "R8");
    do_read(1'b1, 6'd5, 4, "R9");

    // wrap at the top of the space
    do_write(6'd62, 8'hE0, 4, "R7");
    do_read(1'b1, 6'd62, 4, "R7");

    // foreign device bytes get no acknowledge
    bus_start();
    send_byte(8'hA0, ack); check_eq("R1", ack, 0);
    send_byte(8'h00, ack); check_eq("R1", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hD2, ack); check_eq("R1", ack, 0);
    bus_stop();
    // no START: clocked byte ignored
    send_byte(8'hD0, ack); check_eq("R2", ack, 0);
    m_scl = 1'b1; q();
    // STOP after the pointer byte leaves the pointer loaded
    bus_start();
    send_byte(8'hD0, ack); check_eq("R1", ack, 1);
    send_byte(8'd20, ack); check_eq("R3", ack, 1);
    bus_stop();
    exp_ptr = 20;
    do_read(1'b0, 6'd0, 1, "R2");

    // power fail in the middle of the word-address byte
    bus_start();
    send_byte(8'hD0, ack); check_eq("R1", ack, 1);
    for (int i = 7; i >= 4; i--) send_bit(VEC[4][8 + i % 6]);
    pwr_fail = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R10", sda_pull, 0);
    bus_start();
    send_byte(8'hD0, ack); check_eq("R10", ack, 0);
    send_byte(8'h30, ack); check_eq("R10", ack, 0);
    bus_stop();
    pwr_fail = 1'b0;
    q();
    exp_ptr = 0;
    do_read(1'b0, 6'd0, 2, "R10");

    check_eq("R8", we_seen, we_expect);
    check_eq("R11", hold_viol, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule